// File: doc/BRIEF.md
# Up/Down Event Counter Channel with Wrap and Match Flags

This block is one counting channel. A 25-bit count register steps up or down on synchronous single-cycle pulses when counting is enabled. A 24-bit preset register is set by the host, and the index input can copy it into the count. The channel raises three single-cycle, active-high event flags: wrap-up, wrap-down and match. An interrupt controller next to the channel consumes these flags. Any active-low conversion is done at the chip boundary, not here.

A simple write port lets the host do three things: load the count, load the preset, or write an 8-bit control byte. The control byte has two bits that matter. Bit 0 enables counting. Bit 1 enables the index-triggered preset load. The host and the preset can reach only count bits [23:0], and bit 24 keeps its value. A separate clear command zeroes the whole count.

In each cycle an arbiter picks exactly one action for the count register, from highest to lowest priority:
- CLEAR: the clear command is high.
- HOST_LOAD: the host writes the count.
- INDEX_LOAD: an index pulse arrives while index loading is enabled.
- STEP_UP or STEP_DOWN: counting is enabled and exactly one of the up and down pulses is high.
- HOLD: none of the above.

The count register moves from whatever value it holds to the value that the chosen action gives. The flags are registered together with that move.

Top module: `updn_flag_counter`

## Requirements
- R1: After reset (active-low `rst_n`), the count, preset and control byte are zero and all three flags are low.
- R2: With control bit 0 set, an up pulse alone adds one to the count on the next clock and a down pulse alone subtracts one. Both pulses together, or neither, leave the count unchanged.
- R3: With control bit 0 clear, up and down pulses have no effect on the count.
- R4: An up step from 0x1FFFFFF gives a count of 0 and asserts `carry_o` for exactly one cycle. This is the cycle in which the new count is first visible.
- R5: A down step from 0 gives 0x1FFFFFF and asserts `borrow_o` for exactly one cycle, aligned the same way.
- R6: A step whose new count equals the zero-extended preset asserts `compare_o` for that one cycle. A wrap step raises only its wrap flag. Loads and clears raise no flag.
- R7: A host write with `host_sel` = 0 sets count bits [23:0] to `host_wdata`. Bit 24 keeps its value.
- R8: `host_sel` = 1 writes the preset from `host_wdata`. `host_sel` = 2 writes the control byte from `host_wdata[7:0]`. `host_sel` = 3 changes nothing.
- R9: An index pulse with control bit 1 set copies the preset into count bits [23:0] and keeps bit 24. It overrides a step in the same cycle and raises no flag. With control bit 1 clear, the index pulse is ignored.
- R10: `clear_cmd` zeroes the whole count on the next clock. It overrides host count writes and index loads, and it raises no flag.
- R11: At most one of the three flags is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_cmd | input | 1 | Synchronous command that zeroes the count |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 count, 1 preset, 2 control, 3 none |
| host_wdata | input | 24 | Host write data |
| index_i | input | 1 | Index event pulse |
| up_i | input | 1 | Count-up pulse |
| down_i | input | 1 | Count-down pulse |
| count_q | output | 25 | Current count |
| preset_q | output | 24 | Current preset |
| ctrl_q | output | 8 | Current control byte |
| carry_o | output | 1 | Wrap-up flag pulse |
| borrow_o | output | 1 | Wrap-down flag pulse |
| compare_o | output | 1 | Match flag pulse |

## Verification
Some behaviours are checked by assertions on every cycle:
- the flags are mutually exclusive;
- each wrap flag coincides with the wrapped count value;
- a match flag coincides with a count equal to the preset of the previous cycle;
- the count holds when no action can move it;
- a clear lands on zero;
- the preset and control byte change only when written.

Other behaviours can be shown only by the bench's scenarios: the exact step arithmetic, the retention of bit 24 across loads, the arbitration order when clear, host write, index and step pulses collide, and the fact that loads never raise a match flag.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int CNT_W  = 25;
    localparam int LOAD_W = 24;
    localparam int CTRL_W = 8;

    localparam logic [1:0] SEL_COUNT  = 2'd0;
    localparam logic [1:0] SEL_PRESET = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IDX_BIT = 1;

    typedef enum logic [2:0] {
        ACT_HOLD        = 3'd0,
        ACT_CLEAR       = 3'd1,
        ACT_HOST_LOAD   = 3'd2,
        ACT_INDEX_LOAD  = 3'd3,
        ACT_STEP_UP     = 3'd4,
        ACT_STEP_DOWN   = 3'd5
    } step_act_e;

endpackage

// File: rtl/updn_host_regs.sv
module updn_host_regs
    import updn_pkg::*;
#(
    parameter int LW = LOAD_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [1:0]    host_sel,
    input  logic [LW-1:0] host_wdata,
    output logic [LW-1:0] preset_q,
    output logic [CW-1:0] ctrl_q,
    output logic          count_wr
);

    logic preset_wr;
    logic ctrl_wr;

    always_comb begin
        count_wr  = host_we && (host_sel == SEL_COUNT);
        preset_wr = host_we && (host_sel == SEL_PRESET);
        ctrl_wr   = host_we && (host_sel == SEL_CTRL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (preset_wr) preset_q <= host_wdata;
            if (ctrl_wr)   ctrl_q   <= host_wdata[CW-1:0];
        end
    end

    // R8
    preset_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && host_sel == SEL_PRESET) |=> $stable(preset_q));

    // R8
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && host_sel == SEL_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/updn_step_arbiter.sv
module updn_step_arbiter
    import updn_pkg::*;
(
    input  logic      clear_cmd,
    input  logic      count_wr,
    input  logic      index_i,
    input  logic      idx_en,
    input  logic      cnt_en,
    input  logic      up_i,
    input  logic      down_i,
    output step_act_e act
);

    always_comb begin
        if (clear_cmd) begin
            act = ACT_CLEAR;
        end else if (count_wr) begin
            act = ACT_HOST_LOAD;
        end else if (index_i && idx_en) begin
            act = ACT_INDEX_LOAD;
        end else if (cnt_en && up_i && !down_i) begin
            act = ACT_STEP_UP;
        end else if (cnt_en && down_i && !up_i) begin
            act = ACT_STEP_DOWN;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LOAD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  step_act_e     act,
    input  logic [LW-1:0] host_val,
    input  logic [LW-1:0] preset,
    output logic [CW-1:0] count_q,
    output logic          carry_q,
    output logic          borrow_q,
    output logic          compare_q
);

    localparam int HI_W = CW - LW;
    localparam logic [CW-1:0] TOP_VAL = '1;

    logic [CW-1:0] count_n;
    logic [CW-1:0] preset_ext;
    logic          carry_n;
    logic          borrow_n;
    logic          compare_n;

    assign preset_ext = {{HI_W{1'b0}}, preset};

    always_comb begin
        count_n   = count_q;
        carry_n   = 1'b0;
        borrow_n  = 1'b0;
        compare_n = 1'b0;
        unique case (act)
            ACT_HOLD: begin
                count_n = count_q;
            end
            ACT_CLEAR: begin
                count_n = '0;
            end
            ACT_HOST_LOAD: begin
                count_n = {count_q[CW-1:LW], host_val};
            end
            ACT_INDEX_LOAD: begin
                count_n = {count_q[CW-1:LW], preset};
            end
            ACT_STEP_UP: begin
                count_n   = count_q + 1'b1;
                carry_n   = (count_q == TOP_VAL);
                compare_n = !carry_n && (count_n == preset_ext);
            end
            ACT_STEP_DOWN: begin
                count_n   = count_q - 1'b1;
                borrow_n  = (count_q == '0);
                compare_n = !borrow_n && (count_n == preset_ext);
            end
            default: begin
                count_n = count_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            carry_q   <= 1'b0;
            borrow_q  <= 1'b0;
            compare_q <= 1'b0;
        end else begin
            count_q   <= count_n;
            carry_q   <= carry_n;
            borrow_q  <= borrow_n;
            compare_q <= compare_n;
        end
    end

    // R11
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({carry_q, borrow_q, compare_q}));

    // R4
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_q) |-> (count_q == '0) && ($past(count_q) == TOP_VAL));

    // R5
    borrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(borrow_q) |-> (count_q == TOP_VAL) && ($past(count_q) == '0));

    // R6
    compare_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        compare_q |-> (count_q == {{HI_W{1'b0}}, $past(preset)}));

endmodule

// File: rtl/updn_flag_counter.sv
module updn_flag_counter
    import updn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_cmd,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [LOAD_W-1:0] host_wdata,
    input  logic              index_i,
    input  logic              up_i,
    input  logic              down_i,
    output logic [CNT_W-1:0]  count_q,
    output logic [LOAD_W-1:0] preset_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              carry_o,
    output logic              borrow_o,
    output logic              compare_o
);

    logic      count_wr;
    step_act_e act;

    updn_host_regs #(.LW(LOAD_W), .CW(CTRL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_sel  (host_sel),
        .host_wdata(host_wdata),
        .preset_q  (preset_q),
        .ctrl_q    (ctrl_q),
        .count_wr  (count_wr)
    );

    updn_step_arbiter u_arb (
        .clear_cmd(clear_cmd),
        .count_wr (count_wr),
        .index_i  (index_i),
        .idx_en   (ctrl_q[CTRL_IDX_BIT]),
        .cnt_en   (ctrl_q[CTRL_EN_BIT]),
        .up_i     (up_i),
        .down_i   (down_i),
        .act      (act)
    );

    updn_count_core #(.CW(CNT_W), .LW(LOAD_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .host_val (host_wdata),
        .preset   (preset_q),
        .count_q  (count_q),
        .carry_q  (carry_o),
        .borrow_q (borrow_o),
        .compare_q(compare_o)
    );

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_cmd && !(host_we && host_sel == SEL_COUNT) &&
         !(index_i && ctrl_q[CTRL_IDX_BIT]) && !ctrl_q[CTRL_EN_BIT])
        |=> $stable(count_q));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cmd |=> (count_q == '0) && !carry_o && !borrow_o && !compare_o);

endmodule

// File: tb/tb_updn_flag_counter.sv
module tb_updn_flag_counter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic        clr;
        logic        we;
        logic [1:0]  sel;
        logic [23:0] wd;
        logic        idx;
        logic        up;
        logic        dn;
        logic [24:0] cnt;
        logic [2:0]  flg;   // {carry, borrow, compare}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,2'd2,24'h000001,1'b0,1'b0,1'b0,25'h0000000,3'b000,4'd8 }, // R8 enable counting
        '{1'b0,1'b1,2'd1,24'h000005,1'b0,1'b0,1'b0,25'h0000000,3'b000,4'd8 }, // R8 preset = 5
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b0,25'h0000001,3'b000,4'd2 }, // R2 up
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b0,25'h0000002,3'b000,4'd2 }, // R2 up
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b1,25'h0000002,3'b000,4'd2 }, // R2 both
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b0,1'b0,25'h0000002,3'b000,4'd2 }, // R2 none
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b0,1'b1,25'h0000001,3'b000,4'd2 }, // R2 down
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b0,1'b1,25'h0000000,3'b000,4'd2 }, // R2 down
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b0,1'b1,25'h1FFFFFF,3'b010,4'd5 }, // R5 borrow
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b0,25'h0000000,3'b100,4'd4 }, // R4 carry
        '{1'b0,1'b1,2'd0,24'h000004,1'b0,1'b0,1'b0,25'h0000004,3'b000,4'd7 }, // R7 host load
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b0,25'h0000005,3'b001,4'd6 }, // R6 match
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b0,25'h0000006,3'b000,4'd6 }, // R6 one cycle
        '{1'b0,1'b1,2'd2,24'h000000,1'b0,1'b0,1'b0,25'h0000006,3'b000,4'd3 }, // R3 disable
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b0,25'h0000006,3'b000,4'd3 }, // R3 up ignored
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b0,1'b1,25'h0000006,3'b000,4'd3 }, // R3 down ignored
        '{1'b0,1'b0,2'd0,24'h000000,1'b1,1'b0,1'b0,25'h0000006,3'b000,4'd9 }, // R9 index ignored
        '{1'b0,1'b1,2'd2,24'h000003,1'b0,1'b0,1'b0,25'h0000006,3'b000,4'd8 }, // R8 ctrl = 3
        '{1'b0,1'b0,2'd0,24'h000000,1'b1,1'b1,1'b0,25'h0000005,3'b000,4'd9 }, // R9 index wins
        '{1'b1,1'b1,2'd0,24'h000123,1'b1,1'b0,1'b0,25'h0000000,3'b000,4'd10}, // R10 clear wins
        '{1'b0,1'b1,2'd0,24'hFFFFFF,1'b0,1'b0,1'b0,25'h0FFFFFF,3'b000,4'd7 }, // R7
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b0,25'h1000000,3'b000,4'd2 }, // R2 into bit 24
        '{1'b0,1'b1,2'd0,24'h000010,1'b0,1'b0,1'b0,25'h1000010,3'b000,4'd7 }, // R7 bit 24 kept
        '{1'b0,1'b0,2'd0,24'h000000,1'b1,1'b0,1'b0,25'h1000005,3'b000,4'd9 }, // R9 bit 24 kept
        '{1'b0,1'b1,2'd3,24'hABCDEF,1'b0,1'b0,1'b0,25'h1000005,3'b000,4'd8 }, // R8 sel 3
        '{1'b0,1'b1,2'd0,24'hFFFFFF,1'b0,1'b0,1'b0,25'h1FFFFFF,3'b000,4'd7 }, // R7
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b1,1'b0,25'h0000000,3'b100,4'd4 }, // R4 carry
        '{1'b0,1'b0,2'd0,24'h000000,1'b0,1'b0,1'b0,25'h0000000,3'b000,4'd4 }  // R4 one cycle
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_cmd = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [23:0] host_wdata = '0;
    logic        index_i = 1'b0;
    logic        up_i = 1'b0;
    logic        down_i = 1'b0;
    logic [24:0] count_q;
    logic [23:0] preset_q;
    logic [7:0]  ctrl_q;
    logic        carry_o;
    logic        borrow_o;
    logic        compare_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    updn_flag_counter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_cmd (clear_cmd),
        .host_we   (host_we),
        .host_sel  (host_sel),
        .host_wdata(host_wdata),
        .index_i   (index_i),
        .up_i      (up_i),
        .down_i    (down_i),
        .count_q   (count_q),
        .preset_q  (preset_q),
        .ctrl_q    (ctrl_q),
        .carry_o   (carry_o),
        .borrow_o  (borrow_o),
        .compare_o (compare_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", 32'(count_q), 0);
        check("R1 preset", 32'(preset_q), 0);
        check("R1 ctrl", 32'(ctrl_q), 0);
        check("R1 flags", {29'd0, carry_o, borrow_o, compare_o}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            clear_cmd  = VECS[i].clr;
            host_we    = VECS[i].we;
            host_sel   = VECS[i].sel;
            host_wdata = VECS[i].wd;
            index_i    = VECS[i].idx;
            up_i       = VECS[i].up;
            down_i     = VECS[i].dn;
            @(posedge clk);
            #(CLK_PERIOD/4);
            check($sformatf("vector %0d R%0d count", i, VECS[i].req),
                  32'(count_q), 32'(VECS[i].cnt));
            check($sformatf("vector %0d R%0d flags", i, VECS[i].req),
                  {29'd0, carry_o, borrow_o, compare_o}, 32'(VECS[i].flg));
        end

        @(negedge clk);
        clear_cmd = 1'b0; host_we = 1'b0; index_i = 1'b0; up_i = 1'b0; down_i = 1'b0;
        // R8 select 3 left preset and control untouched
        check("R8 preset after sel 3", 32'(preset_q), 32'h5);
        check("R8 ctrl after sel 3", 32'(ctrl_q), 32'h3);

        // R6 preset of zero: a down step onto 0 matches, an up wrap onto 0 only carries
        host_we = 1'b1; host_sel = 2'd1; host_wdata = 24'h0;
        @(negedge clk);
        host_sel = 2'd0; host_wdata = 24'h1;
        @(negedge clk);
        host_we = 1'b0; down_i = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R6 match at zero", {29'd0, carry_o, borrow_o, compare_o}, 32'b001);

        // R1 reset in mid-run
        @(negedge clk);
        down_i = 1'b0;
        rst_n = 1'b0;
        #(CLK_PERIOD/4);
        check("R1 count after reset", 32'(count_q), 0);
        check("R1 ctrl after reset", 32'(ctrl_q), 0);
        @(negedge clk);
        rst_n = 1'b1;
        up_i = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        // R3 counting disabled after reset
        check("R3 hold after reset", 32'(count_q), 0);
        @(negedge clk);
        up_i = 1'b0;
        done = 1'b1;
        summary();
    end

endmodule